// File: doc/BRIEF.md
# Receive DMA Byte Counter

This block tracks how much room is left in the receive buffer that a DMA engine is currently filling with incoming frame data. The room is counted in units of 8 bytes. Each pulse on the transfer strobe means one such unit has gone to memory, and the counter drops by one. When the last unit of a buffer has been written, the counter reloads from the size of the next buffer. The same cycle carries a one-cycle restart pulse that tells the DMA engine to start on that buffer.

Two size inputs are available, one for a header buffer and one for a normal data buffer. A select input picks which of them feeds each load. The live count is published as a read-only 32-bit status word. The count field sits at bit 3 and up, so the word reads directly as a byte value. All other bits are zero.

Top module: `rx_dma_bytecount`

## Requirements
- R1: Bits 10:3 of `status_word` carry the current count in 8-byte units, and bits 2:0 always read 0, so the word equals the remaining byte count.
- R2: Bits 31:11 of `status_word` always read 0, including the reserved bits 13:11.
- R3: While `rst` is high at a clock edge, the count loads from `hdr_units` if `use_hdr` is 1 or from `data_units` if `use_hdr` is 0, and `restart` is 0.
- R4: A `beat` of 1 while the count is 2 or more lowers the count by exactly one at the next edge.
- R5: With `beat` at 0 and a nonzero count, the count holds its value.
- R6: A `beat` of 1 while the count is 1 ends the buffer. At the next edge the count loads the selected size and `restart` is 1 for that one cycle.
- R7: `use_hdr` has no effect on the count except at a load. Changing it partway through a buffer does not alter the count sequence.
- R8: A count of 0, from a zero-sized buffer, triggers a load of the selected size and a `restart` pulse at the next edge, whether or not `beat` is high.
- R9: `restart` is 0 in every cycle that does not follow an end-of-buffer condition (R6 or R8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; loads the selected size |
| hdr_units | input | 8 | Header buffer size in 8-byte units |
| data_units | input | 8 | Data buffer size in 8-byte units |
| use_hdr | input | 1 | 1 selects the header size for the next load, 0 selects the data size |
| beat | input | 1 | One 8-byte unit moved to memory this cycle |
| restart | output | 1 | One-cycle pulse: a new buffer was loaded, DMA restarts |
| status_word | output | 32 | Read-only count word, count in bits 10:3 |

## Verification
The bench builds the block with its default parameters: an 8-bit count field at bit offset 3 inside a 32-bit word. This puts the all-ones size of 255 units (2040 bytes) within reach, so the top of the field can be checked for bleed into the reserved bits. Small sizes of 2, 3 and 5 units make every reload reachable in a few beats. A zero data size covers the empty-buffer reload path.

// File: rtl/rxbc_pkg.sv
package rxbc_pkg;
  localparam int unsigned DEF_CNT_W    = 8;
  localparam int unsigned DEF_UNIT_LOG = 3;
  localparam int unsigned DEF_REG_W    = 32;

  typedef enum logic [1:0] {
    EV_IDLE,
    EV_STEP,
    EV_END
  } rxbc_event_e;
endpackage

// File: rtl/rxbc_size_sel.sv
module rxbc_size_sel #(
  parameter int unsigned CNT_W = 8
) (
  input  logic [CNT_W-1:0] hdr_units,
  input  logic [CNT_W-1:0] data_units,
  input  logic             use_hdr,
  output logic [CNT_W-1:0] next_units
);
  always_comb begin
    next_units = use_hdr ? hdr_units : data_units;
  end
endmodule

// File: rtl/rxbc_counter.sv
module rxbc_counter
  import rxbc_pkg::*;
#(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] load_units,
  input  logic             beat,
  output logic [CNT_W-1:0] count,
  output logic             restart
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  rxbc_event_e ev;

  always_comb begin
    if (count == ZERO || (beat && count == ONE)) ev = EV_END;
    else if (beat)                               ev = EV_STEP;
    else                                         ev = EV_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count   <= load_units;
      restart <= 1'b0;
    end else begin
      unique case (ev)
        EV_END: begin
          count   <= load_units;
          restart <= 1'b1;
        end
        EV_STEP: begin
          count   <= count - ONE;
          restart <= 1'b0;
        end
        default: begin
          restart <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/rxbc_status.sv
module rxbc_status #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned UNIT_LOG = 3,
  parameter int unsigned REG_W    = 32
) (
  input  logic [CNT_W-1:0] count,
  output logic [REG_W-1:0] word
);
  localparam int unsigned FIELD_HI = UNIT_LOG + CNT_W - 1;

  for (genvar b = 0; b < REG_W; b++) begin : g_bit
    if (b >= UNIT_LOG && b <= FIELD_HI) begin : g_field
      assign word[b] = count[b - UNIT_LOG];
    end else begin : g_zero
      assign word[b] = 1'b0;
    end
  end
endmodule

// File: rtl/rx_dma_bytecount.sv
module rx_dma_bytecount
  import rxbc_pkg::*;
#(
  parameter int unsigned CNT_W    = DEF_CNT_W,
  parameter int unsigned UNIT_LOG = DEF_UNIT_LOG,
  parameter int unsigned REG_W    = DEF_REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] hdr_units,
  input  logic [CNT_W-1:0] data_units,
  input  logic             use_hdr,
  input  logic             beat,
  output logic             restart,
  output logic [REG_W-1:0] status_word
);
  logic [CNT_W-1:0] next_units;
  logic [CNT_W-1:0] count;

  rxbc_size_sel #(.CNT_W(CNT_W)) sel_i (
    .hdr_units  (hdr_units),
    .data_units (data_units),
    .use_hdr    (use_hdr),
    .next_units (next_units)
  );

  rxbc_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk        (clk),
    .rst        (rst),
    .load_units (next_units),
    .beat       (beat),
    .count      (count),
    .restart    (restart)
  );

  rxbc_status #(.CNT_W(CNT_W), .UNIT_LOG(UNIT_LOG), .REG_W(REG_W)) stat_i (
    .count (count),
    .word  (status_word)
  );
endmodule

// File: rtl/rx_dma_bytecount_chk.sv
module rx_dma_bytecount_chk #(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned UNIT_LOG = 3,
  parameter int unsigned REG_W    = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [CNT_W-1:0] hdr_units,
  input logic [CNT_W-1:0] data_units,
  input logic             use_hdr,
  input logic             beat,
  input logic             restart,
  input logic [REG_W-1:0] status_word
);
  localparam int unsigned FIELD_HI = UNIT_LOG + CNT_W - 1;

  logic [CNT_W-1:0] cnt_v;
  logic [CNT_W-1:0] sel_v;
  assign cnt_v = status_word[FIELD_HI:UNIT_LOG];
  assign sel_v = use_hdr ? hdr_units : data_units;

  p_low_zero_r1: assert property (@(posedge clk) disable iff (rst)
    status_word[UNIT_LOG-1:0] == '0);

  p_upper_zero_r2: assert property (@(posedge clk) disable iff (rst)
    status_word[REG_W-1:FIELD_HI+1] == '0);

  p_reset_load_r3: assert property (@(posedge clk)
    rst |=> (!restart && cnt_v == $past(sel_v)));

  p_decrement_r4: assert property (@(posedge clk) disable iff (rst)
    (beat && cnt_v > CNT_W'(1)) |=> cnt_v == $past(cnt_v) - CNT_W'(1));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!beat && cnt_v != '0) |=> (cnt_v == $past(cnt_v) && !restart));

  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (beat && cnt_v == CNT_W'(1)) |=> (restart && cnt_v == $past(sel_v)));

  p_empty_reload_r8: assert property (@(posedge clk) disable iff (rst)
    (cnt_v == '0) |=> (restart && cnt_v == $past(sel_v)));

  p_no_stray_restart_r9: assert property (@(posedge clk) disable iff (rst)
    (cnt_v > CNT_W'(1)) |=> !restart);
endmodule

bind rx_dma_bytecount rx_dma_bytecount_chk #(
  .CNT_W(CNT_W), .UNIT_LOG(UNIT_LOG), .REG_W(REG_W)
) chk_i (
  .clk         (clk),
  .rst         (rst),
  .hdr_units   (hdr_units),
  .data_units  (data_units),
  .use_hdr     (use_hdr),
  .beat        (beat),
  .restart     (restart),
  .status_word (status_word)
);

// File: tb/rx_dma_bytecount_tb_top.sv
module rx_dma_bytecount_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  hdr_units = 8'd3;
  logic [7:0]  data_units = 8'd5;
  logic        use_hdr = 1'b0;
  logic        beat = 1'b0;
  logic        restart;
  logic [31:0] status_word;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rx_dma_bytecount dut_i (
    .clk(clk), .rst(rst), .hdr_units(hdr_units), .data_units(data_units),
    .use_hdr(use_hdr), .beat(beat), .restart(restart), .status_word(status_word)
  );

  // {use_hdr, beat, expected count[7:0], expected restart}; hdr=3, data=5
  localparam logic [10:0] VEC [0:11] = '{
    {1'b0, 1'b1, 8'd4, 1'b0},  // R4
    {1'b0, 1'b0, 8'd4, 1'b0},  // R5
    {1'b0, 1'b1, 8'd3, 1'b0},  // R4
    {1'b1, 1'b1, 8'd2, 1'b0},  // R7 select change mid-buffer
    {1'b0, 1'b1, 8'd1, 1'b0},  // R4
    {1'b1, 1'b1, 8'd3, 1'b1},  // R6 reload header size
    {1'b1, 1'b0, 8'd3, 1'b0},  // R9
    {1'b1, 1'b1, 8'd2, 1'b0},  // R4
    {1'b0, 1'b1, 8'd1, 1'b0},  // R7
    {1'b0, 1'b1, 8'd5, 1'b1},  // R6 reload data size
    {1'b0, 1'b1, 8'd4, 1'b0},  // R9
    {1'b0, 1'b0, 8'd4, 1'b0}   // R5
  };

  task automatic check(input string req, input logic [31:0] exp_word, input logic exp_rs);
    n_chk++;
    if (status_word !== exp_word || restart !== exp_rs) begin
      n_bad++;
      $display("FAIL %s: word=%h restart=%b expected word=%h restart=%b",
               req, status_word, restart, exp_word, exp_rs);
    end
  endtask

  function automatic logic [31:0] w(input logic [7:0] units);
    return {21'b0, units, 3'b0};
  endfunction

  task automatic cyc(input logic h, input logic b);
    use_hdr = h;
    beat = b;
    @(negedge clk);
  endtask

  task automatic do_reset(input logic h);
    rst = 1'b1;
    use_hdr = h;
    beat = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset(1'b0);
    check("R3 reset load data", w(8'd5), 1'b0);

    for (int i = 0; i < 12; i++) begin
      cyc(VEC[i][10], VEC[i][9]);
      check($sformatf("R4/R5/R6/R7 vector %0d", i), w(VEC[i][8:1]), VEC[i][0]);
    end

    do_reset(1'b1);
    check("R3 reset load header", w(8'd3), 1'b0);

    data_units = 8'd255;
    do_reset(1'b0);
    check("R1 R2 full field 0x7F8", 32'h0000_07F8, 1'b0);
    cyc(1'b0, 1'b1);
    check("R1 decrement from full", w(8'd254), 1'b0);

    data_units = 8'd0;
    do_reset(1'b0);
    check("R8 zero load after reset", w(8'd0), 1'b0);
    data_units = 8'd2;
    cyc(1'b0, 1'b0);
    check("R8 empty buffer reloads without beat", w(8'd2), 1'b1);
    cyc(1'b0, 1'b1);
    check("R9 restart drops after one cycle", w(8'd1), 1'b0);
    cyc(1'b0, 1'b0);
    check("R5 hold at one", w(8'd1), 1'b0);
    cyc(1'b0, 1'b1);
    check("R6 end of buffer", w(8'd2), 1'b1);

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule